// File: doc/BRIEF.md
# Banked 16-bit IO Word Port

This block sits on a synchronous model of a 20-bit address, 16-bit data system bus with active-low read, write and byte-high-enable strobes and a memory/IO select line. It recognises IO cycles aimed at one configured 16-bit port address. For that word it produces four separate strobes: read and write, for the low byte lane and for the high byte lane.

A 16-bit output latch and a 16-bit input path share the one word address. The write strobes load the latch one lane at a time on the clock edge. The read strobes steer the device input pins onto a read-data bus that is zero when idle, and they raise a valid flag. The read strobes are split per lane, so a byte read of one bank never signals a read side effect to the device behind the other bank. A 16-bit transfer moves both lanes in a single bus cycle.

Top module: `io_word_port`

## Requirements
- R1: When `mem_sel` is 1 (a memory cycle), all four lane strobes stay 0, `rd_valid` is 0 and `port_q` does not change.
- R2: Matching compares only address bits 15..1 with `PORT_ADDR[15:1]`. Bits 19..16 and bit 0 never affect whether the cycle matches.
- R3: On a matched IO cycle, the low lane is selected when `bus_addr[0]`=0 and the high lane when `bhe_n`=0. `bhe_n`=1 together with `bus_addr[0]`=1 selects no lane.
- R4: On a clock edge where `wr_lo_en` is 1, `port_q[7:0]` takes `bus_wdata[7:0]`. On a clock edge where `wr_hi_en` is 1, `port_q[15:8]` takes `bus_wdata[15:8]`. A lane whose strobe is 0 keeps its value.
- R5: A read strobe of a lane is 1 only while `rd_n` is 0 and that lane is selected. A write cycle or an access to the other lane alone never raises it.
- R6: `rd_data[7:0]` equals `dev_in[7:0]` when `rd_lo_en` is 1, and is 0 otherwise. `rd_data[15:8]` equals `dev_in[15:8]` when `rd_hi_en` is 1, and is 0 otherwise. `rd_valid` is the OR of the two read strobes.
- R7: While `rst_n` is 0, `port_q` is 0.
- R8: A write strobe of a lane is 1 only while `wr_n` is 0 and that lane is selected. With `wr_n` at 1, `port_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Bus address |
| bus_wdata | input | 16 | Write data from the bus master |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bhe_n | input | 1 | Active-low high byte lane enable |
| mem_sel | input | 1 | 1 = memory cycle, 0 = IO cycle |
| dev_in | input | 16 | Pins of the input device |
| rd_lo_en | output | 1 | Low lane read strobe |
| rd_hi_en | output | 1 | High lane read strobe |
| wr_lo_en | output | 1 | Low lane write strobe |
| wr_hi_en | output | 1 | High lane write strobe |
| port_q | output | 16 | Latched output port |
| rd_data | output | 16 | Read data, zero when no lane is read |
| rd_valid | output | 1 | A read lane is active |

## Verification
The assertions assume that the bus inputs are stable around each rising edge and that the strobes are held for whole cycles, as a synchronous bus model delivers them. The properties make no assumption that read and write are exclusive, so they hold even if both strobes are low at once. The stimulus changes every input only on falling edges. It draws addresses from a mix of exact matches, matches that differ only in bits 19..16 or bit 0, and random addresses. It draws `rd_n`, `wr_n`, `bhe_n` and `mem_sel` at random, which also produces cycles where read and write are low together.

// File: rtl/io_word_port.sv
module io_word_port #(
  parameter int          ADDR_W    = 20,
  parameter int          DATA_W    = 16,
  parameter int          PORT_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h03C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              bhe_n,
  input  logic              mem_sel,
  input  logic [DATA_W-1:0] dev_in,
  output logic              rd_lo_en,
  output logic              rd_hi_en,
  output logic              wr_lo_en,
  output logic              wr_hi_en,
  output logic [DATA_W-1:0] port_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int LANE_W = DATA_W / 2;

  logic hit, lo_sel, hi_sel;
  logic unused_upper;

  assign unused_upper = ^bus_addr[ADDR_W-1:PORT_W];
  assign hit    = !mem_sel && (bus_addr[PORT_W-1:1] == PORT_ADDR[PORT_W-1:1]);
  assign lo_sel = hit && !bus_addr[0];
  assign hi_sel = hit && !bhe_n;

  assign rd_lo_en = lo_sel && !rd_n;
  assign rd_hi_en = hi_sel && !rd_n;
  assign wr_lo_en = lo_sel && !wr_n;
  assign wr_hi_en = hi_sel && !wr_n;

  assign rd_data  = {rd_hi_en ? dev_in[DATA_W-1:LANE_W] : LANE_W'(0),
                     rd_lo_en ? dev_in[LANE_W-1:0]      : LANE_W'(0)};
  assign rd_valid = rd_lo_en || rd_hi_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
    end else begin
      if (wr_lo_en) port_q[LANE_W-1:0]      <= bus_wdata[LANE_W-1:0];
      if (wr_hi_en) port_q[DATA_W-1:LANE_W] <= bus_wdata[DATA_W-1:LANE_W];
    end
  end
endmodule

// File: rtl/io_word_port_chk.sv
module io_word_port_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_n,
  input logic              wr_n,
  input logic              bhe_n,
  input logic              mem_sel,
  input logic [DATA_W-1:0] dev_in,
  input logic              rd_lo_en,
  input logic              rd_hi_en,
  input logic              wr_lo_en,
  input logic              wr_hi_en,
  input logic [DATA_W-1:0] port_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);
  localparam int LANE_W = DATA_W / 2;

  p_mem_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> !(rd_lo_en || rd_hi_en || wr_lo_en || wr_hi_en))
    else $error("p_mem_quiet_r1");

  p_no_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bhe_n && bus_addr[0]) |-> !(rd_lo_en || rd_hi_en || wr_lo_en || wr_hi_en))
    else $error("p_no_lane_r3");

  p_lo_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_en |=> port_q[LANE_W-1:0] == $past(bus_wdata[LANE_W-1:0]))
    else $error("p_lo_load_r4");

  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi_en |=> $stable(port_q[DATA_W-1:LANE_W]))
    else $error("p_hi_hold_r4");

  p_rd_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo_en || rd_hi_en) |-> !rd_n)
    else $error("p_rd_strobe_r5");

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0)
    else $error("p_idle_zero_r6");

  p_lo_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_en |-> rd_data[LANE_W-1:0] == dev_in[LANE_W-1:0])
    else $error("p_lo_data_r6");

  p_wr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(port_q))
    else $error("p_wr_idle_r8");
endmodule

bind io_word_port io_word_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_io_word_port.sv
module tb_io_word_port;
  localparam logic [15:0] PA = 16'h03C4;

  logic        clk = 0, rst_n = 0;
  logic [19:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, dev_in = '0;
  logic        rd_n = 1, wr_n = 1, bhe_n = 1, mem_sel = 1;
  logic        rd_lo_en, rd_hi_en, wr_lo_en, wr_hi_en, rd_valid;
  logic [15:0] port_q, rd_data;

  int tests = 0, fails = 0;
  logic [15:0] model = '0;

  io_word_port #(.PORT_ADDR(PA)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_en(logic [19:0] a, logic b, logic r, logic w, logic m);
    logic h, lo, hi;
    h  = !m && (a[15:1] == PA[15:1]);
    lo = h && !a[0];
    hi = h && !b;
    return {lo && !r, hi && !r, lo && !w, hi && !w};
  endfunction

  function automatic logic [16:0] exp_rd(logic [3:0] en, logic [15:0] d);
    logic [15:0] v;
    v = {en[2] ? d[15:8] : 8'h00, en[3] ? d[7:0] : 8'h00};
    return {en[3] | en[2], v};
  endfunction

  task automatic drive(input logic [19:0] a, input logic b, input logic r,
                       input logic w, input logic m, input logic [15:0] wd,
                       input logic [15:0] di, input string req);
    logic [3:0] e;
    @(negedge clk);
    chk("R4 port_q", port_q, model);
    bus_addr = a; bhe_n = b; rd_n = r; wr_n = w; mem_sel = m;
    bus_wdata = wd; dev_in = di;
    #1;
    e = exp_en(a, b, r, w, m);
    chk({req, " strobes"}, {rd_lo_en, rd_hi_en, wr_lo_en, wr_hi_en}, e);
    chk("R6 read data", {rd_valid, rd_data}, exp_rd(e, di));
    if (e[1]) model[7:0]  = wd[7:0];
    if (e[0]) model[15:8] = wd[15:8];
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #12;
    chk("R7 reset port_q", port_q, 16'h0000);
    @(negedge clk); rst_n = 1;
    // R1: memory cycle at the port address
    drive({4'h0, PA}, 0, 0, 0, 1, 16'hAAAA, 16'h1234, "R1");
    chk("R1 port_q unchanged", port_q, 16'h0000);
    // R3: all four lane combinations, 16-bit write
    drive({4'h0, PA}, 0, 1, 0, 0, 16'hBEEF, 16'h0, "R3 both");
    drive({4'h0, PA}, 1, 1, 0, 0, 16'h1111, 16'h0, "R3 low");
    drive({4'h0, PA | 16'h1}, 0, 1, 0, 0, 16'h2222, 16'h0, "R3 high");
    drive({4'h0, PA | 16'h1}, 1, 1, 0, 0, 16'h3333, 16'h0, "R3 none");
    // R2: upper bits ignored, A0 not part of match
    drive({4'hF, PA}, 0, 0, 1, 0, 16'h0, 16'hC3A5, "R2 upper");
    drive({4'h5, PA ^ 16'h0002}, 0, 0, 0, 0, 16'h5555, 16'hFFFF, "R2 miss");
    // R5: byte read of high lane only, and pure write raises no read
    drive({4'h0, PA | 16'h1}, 0, 0, 1, 0, 16'h0, 16'h9876, "R5 hi read");
    chk("R5 low read idle", rd_lo_en, 1'b0);
    drive({4'h0, PA}, 0, 1, 0, 0, 16'h7E57, 16'h0, "R5 write only");
    chk("R5 no read on write", rd_valid, 1'b0);
    // R8: strobes idle, value held
    drive({4'h0, PA}, 0, 1, 1, 0, 16'hDEAD, 16'hABCD, "R8 idle");
    @(negedge clk);
    chk("R8 held port_q", port_q, 16'h7E57);
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = $urandom;
      if (sel < 3) a[15:1] = PA[15:1];
      drive(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 4) == 0),
            16'($urandom), 16'($urandom), "R3 random");
    end
    @(negedge clk);
    chk("R4 final port_q", port_q, model);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule